// File: doc/BRIEF.md
# Hardware Watchpoint Chaining Unit

This block watches each CPU access (an instruction fetch address, a load or store address, or load or store data) and tests it against a bank of programmable comparator slots. Each slot has its own reference value and control byte. The slot results, plus two conditions taken from the counters, feed a ripple chain of watchpoints. In the chain, each watchpoint can stand alone, be ANDed with the chained result of the watchpoint before it, or be ORed with it.

Each matching watchpoint does two things. It adds one to the watchpoint counter it is assigned to, if that counter is enabled. It also raises a break request, if its break-enable bit is set. A single-step mode asks for a stop on every instruction fetch, whatever the watchpoints say. The debug logic around the block writes the configuration. It reads the registered hit vector, the break request and the two counters, all valid one cycle after the access.

Top module: `wpChainUnit`

## Requirements
- R1: While `dbgEnable` is low or `cpuInReset` is high, an access yields no hit bits and no break request one cycle later, and both counters keep their values.
- R2: Watchpoints are evaluated only when an access is present (`accKind` 1..5) and at least one `breakEn` bit or one `cntEnable` bit is set; otherwise `wpHit` is zero in the next cycle.
- R3: A slot's own condition can be true only if its present bit (control bit 0) is set and its access selector (control bits 7:5) is nonzero. Selector 1 takes an instruction fetch (`accKind`=1), 2 a load address (2), 3 a store address (3), 4 either address kind, 5 load data (4), 6 store data (5), and 7 either data kind.
- R4: The condition field (control bits 3:1) selects 0 masked (bitwise AND nonzero), 1 equal, 2 not equal, 3 less, 4 less-or-equal, 5 greater, 6 greater-or-equal, and 7 never true. Control bit 4 makes the ordering comparisons two's-complement signed; when it is clear they are unsigned. The access value is the left operand.
- R5: The 2-bit chain mode of watchpoint i sits at `chainMode[2i+1:2i]`. Mode 0 gives the own condition, mode 1 ANDs it with the chained result of watchpoint i-1, mode 2 ORs it with that result, and mode 3 never matches. Watchpoint 0 uses its own condition as its predecessor.
- R6: Watchpoint NCMP has as its own condition "counter 0 equals `cntMatch0`", and watchpoint NCMP+1 has "counter 1 equals `cntMatch1`", both taken from the counter values before the access. The own condition of watchpoint NCMP+2 (the external input) is always false.
- R7: Each matching watchpoint adds exactly one to the counter chosen by its `cntSel` bit (0 = counter 0, 1 = counter 1), but only when `cntEnable` for that counter is set. Counts from several watchpoints add up in the same cycle, and each counter wraps modulo 2^CW.
- R8: `breakReq` is high one cycle after an evaluated access when any matching watchpoint has its `breakEn` bit set.
- R9: When `singleStep` is high and the unit is active, every instruction fetch raises `breakReq` one cycle later, even with all watchpoint enables clear.
- R10: `wpHit` and `breakReq` describe only the access of the previous cycle, and clear after a cycle with no access.
- R11: After reset, `wpHit`, `breakReq`, `cnt0` and `cnt1` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgEnable | input | 1 | Debug unit enabled |
| cpuInReset | input | 1 | CPU held in debug reset |
| singleStep | input | 1 | Stop on every instruction fetch |
| accKind | input | 3 | Access kind: 0 none, 1 fetch, 2 load addr, 3 store addr, 4 load data, 5 store data |
| accValue | input | DW | Address or data of the access |
| slotCtrl | input | 8*NCMP | Per-slot control byte |
| slotValue | input | DW*NCMP | Per-slot reference value |
| chainMode | input | 2*(NCMP+3) | Chain mode per watchpoint |
| cntSel | input | NCMP+3 | Counter assignment per watchpoint |
| breakEn | input | NCMP+3 | Break enable per watchpoint |
| cntEnable | input | 2 | Counter 1/0 enables |
| cntMatch0 | input | CW | Match value for counter 0 |
| cntMatch1 | input | CW | Match value for counter 1 |
| breakReq | output | 1 | Registered break request |
| wpHit | output | NCMP+3 | Registered per-access watchpoint hit vector |
| cnt0 | output | CW | Counter 0 |
| cnt1 | output | CW | Counter 1 |

## Verification
The bench builds the unit with NCMP=4, DW=8 and CW=4, which gives seven watchpoints and a counter that wraps after sixteen steps. With those values the bench sweeps every condition code, signedness, selector and access kind against sign-boundary values. It also steps through all 16384 chain-mode settings while the counters run through many wraps, so the counter-driven watchpoints meet their match values again and again. Separate passes cover gating, single-step and the clearing of the hit vector.

// File: rtl/wpchain_pkg.sv
package wpchain_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE   = 3'd0,
    ACC_IFETCH = 3'd1,
    ACC_LDADDR = 3'd2,
    ACC_STADDR = 3'd3,
    ACC_LDDATA = 3'd4,
    ACC_STDATA = 3'd5
  } accKind_e;

  typedef enum logic [2:0] {
    SEL_OFF = 3'd0,
    SEL_IFA = 3'd1,
    SEL_LDA = 3'd2,
    SEL_STA = 3'd3,
    SEL_LSA = 3'd4,
    SEL_LDD = 3'd5,
    SEL_STD = 3'd6,
    SEL_LSD = 3'd7
  } slotSel_e;

  typedef enum logic [2:0] {
    CND_MASK = 3'd0,
    CND_EQ   = 3'd1,
    CND_NE   = 3'd2,
    CND_LT   = 3'd3,
    CND_LE   = 3'd4,
    CND_GT   = 3'd5,
    CND_GE   = 3'd6,
    CND_NONE = 3'd7
  } slotCond_e;

  typedef struct packed {
    slotSel_e  sel;
    logic      isSigned;
    slotCond_e cond;
    logic      present;
  } slotCtrl_t;

  localparam int SLOT_CTRL_W = $bits(slotCtrl_t);

  // strobes from control to datapath
  typedef struct packed {
    logic evalEn;
    logic stepBrk;
  } ctlStrobe_t;

endpackage

// File: rtl/wpSlot.sv
module wpSlot
  import wpchain_pkg::*;
#(
  parameter int DW = 32
) (
  input  slotCtrl_t       ctrl,
  input  logic [DW-1:0]   refValue,
  input  logic [2:0]      accKind,
  input  logic [DW-1:0]   accValue,
  output logic            hit
);

  logic kindOk, isEq, isLt, cmpOk;

  always_comb begin
    unique case (ctrl.sel)
      SEL_IFA: kindOk = (accKind == ACC_IFETCH);
      SEL_LDA: kindOk = (accKind == ACC_LDADDR);
      SEL_STA: kindOk = (accKind == ACC_STADDR);
      SEL_LSA: kindOk = (accKind == ACC_LDADDR) || (accKind == ACC_STADDR);
      SEL_LDD: kindOk = (accKind == ACC_LDDATA);
      SEL_STD: kindOk = (accKind == ACC_STDATA);
      SEL_LSD: kindOk = (accKind == ACC_LDDATA) || (accKind == ACC_STDATA);
      default: kindOk = 1'b0;
    endcase
  end

  assign isEq = (accValue == refValue);
  assign isLt = ctrl.isSigned ? ($signed(accValue) < $signed(refValue))
                              : (accValue < refValue);

  always_comb begin
    unique case (ctrl.cond)
      CND_MASK: cmpOk = |(accValue & refValue);
      CND_EQ:   cmpOk = isEq;
      CND_NE:   cmpOk = !isEq;
      CND_LT:   cmpOk = isLt;
      CND_LE:   cmpOk = isLt || isEq;
      CND_GT:   cmpOk = !(isLt || isEq);
      CND_GE:   cmpOk = !isLt;
      default:  cmpOk = 1'b0;
    endcase
  end

  assign hit = ctrl.present && kindOk && cmpOk;

endmodule

// File: rtl/wpControl.sv
module wpControl
  import wpchain_pkg::*;
#(
  parameter int NWP = 11
) (
  input  logic            dbgEnable,
  input  logic            cpuInReset,
  input  logic            singleStep,
  input  logic [2:0]      accKind,
  input  logic [NWP-1:0]  breakEn,
  input  logic [1:0]      cntEnable,
  output ctlStrobe_t      strobe
);

  logic active, accValid, anyEnable;

  assign active    = dbgEnable && !cpuInReset;
  assign accValid  = (accKind >= ACC_IFETCH) && (accKind <= ACC_STDATA);
  assign anyEnable = (|breakEn) || (|cntEnable);

  assign strobe.evalEn  = active && accValid && anyEnable;
  assign strobe.stepBrk = active && singleStep && (accKind == ACC_IFETCH);

endmodule

// File: rtl/wpDatapath.sv
module wpDatapath
  import wpchain_pkg::*;
#(
  parameter  int NCMP = 8,
  parameter  int DW   = 32,
  parameter  int CW   = 16,
  localparam int NWP  = NCMP + 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  strobe,
  input  logic [2:0]                  accKind,
  input  logic [DW-1:0]               accValue,
  input  logic [NCMP*SLOT_CTRL_W-1:0] slotCtrl,
  input  logic [NCMP*DW-1:0]          slotValue,
  input  logic [2*NWP-1:0]            chainMode,
  input  logic [NWP-1:0]              cntSel,
  input  logic [NWP-1:0]              breakEn,
  input  logic [1:0]                  cntEnable,
  input  logic [CW-1:0]               cntMatch0,
  input  logic [CW-1:0]               cntMatch1,
  output logic                        breakReq,
  output logic [NWP-1:0]              wpHit,
  output logic [CW-1:0]               cnt0,
  output logic [CW-1:0]               cnt1
);

  logic [NWP-1:0] ownCond, chained, hits;
  logic [CW-1:0]  cnt0Q, cnt1Q, inc0, inc1;
  logic           brkNext;

  for (genvar g = 0; g < NCMP; g++) begin : g_slot
    wpSlot #(.DW(DW)) i_slot (
      .ctrl     (slotCtrl[g*SLOT_CTRL_W +: SLOT_CTRL_W]),
      .refValue (slotValue[g*DW +: DW]),
      .accKind  (accKind),
      .accValue (accValue),
      .hit      (ownCond[g])
    );
  end

  assign ownCond[NCMP]   = (cnt0Q == cntMatch0);
  assign ownCond[NCMP+1] = (cnt1Q == cntMatch1);
  assign ownCond[NCMP+2] = 1'b0;  // external watchpoint tied off

  // ripple chain: each stage sees the chained result of the one before
  always_comb begin
    logic prev;
    logic res;
    prev = ownCond[0];
    for (int i = 0; i < NWP; i++) begin
      unique case (chainMode[2*i +: 2])
        2'd0:    res = ownCond[i];
        2'd1:    res = ownCond[i] && prev;
        2'd2:    res = ownCond[i] || prev;
        default: res = 1'b0;
      endcase
      chained[i] = res;
      prev       = res;
    end
  end

  assign hits = strobe.evalEn ? chained : '0;

  always_comb begin
    inc0 = '0;
    inc1 = '0;
    for (int i = 0; i < NWP; i++) begin
      if (hits[i] && !cntSel[i]) inc0 = inc0 + CW'(1);
      if (hits[i] &&  cntSel[i]) inc1 = inc1 + CW'(1);
    end
  end

  assign brkNext = strobe.stepBrk || (|(hits & breakEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt0Q    <= '0;
      cnt1Q    <= '0;
      wpHit    <= '0;
      breakReq <= 1'b0;
    end else begin
      if (cntEnable[0]) cnt0Q <= cnt0Q + inc0;
      if (cntEnable[1]) cnt1Q <= cnt1Q + inc1;
      wpHit    <= hits;
      breakReq <= brkNext;
    end
  end

  assign cnt0 = cnt0Q;
  assign cnt1 = cnt1Q;

endmodule

// File: rtl/wpChainUnit.sv
module wpChainUnit
  import wpchain_pkg::*;
#(
  parameter  int NCMP = 8,
  parameter  int DW   = 32,
  parameter  int CW   = 16,
  localparam int NWP  = NCMP + 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        dbgEnable,
  input  logic                        cpuInReset,
  input  logic                        singleStep,
  input  logic [2:0]                  accKind,
  input  logic [DW-1:0]               accValue,
  input  logic [NCMP*SLOT_CTRL_W-1:0] slotCtrl,
  input  logic [NCMP*DW-1:0]          slotValue,
  input  logic [2*NWP-1:0]            chainMode,
  input  logic [NWP-1:0]              cntSel,
  input  logic [NWP-1:0]              breakEn,
  input  logic [1:0]                  cntEnable,
  input  logic [CW-1:0]               cntMatch0,
  input  logic [CW-1:0]               cntMatch1,
  output logic                        breakReq,
  output logic [NWP-1:0]              wpHit,
  output logic [CW-1:0]               cnt0,
  output logic [CW-1:0]               cnt1
);

  ctlStrobe_t strobe;

  wpControl #(.NWP(NWP)) i_ctl (
    .dbgEnable  (dbgEnable),
    .cpuInReset (cpuInReset),
    .singleStep (singleStep),
    .accKind    (accKind),
    .breakEn    (breakEn),
    .cntEnable  (cntEnable),
    .strobe     (strobe)
  );

  wpDatapath #(.NCMP(NCMP), .DW(DW), .CW(CW)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .accKind   (accKind),
    .accValue  (accValue),
    .slotCtrl  (slotCtrl),
    .slotValue (slotValue),
    .chainMode (chainMode),
    .cntSel    (cntSel),
    .breakEn   (breakEn),
    .cntEnable (cntEnable),
    .cntMatch0 (cntMatch0),
    .cntMatch1 (cntMatch1),
    .breakReq  (breakReq),
    .wpHit     (wpHit),
    .cnt0      (cnt0),
    .cnt1      (cnt1)
  );

endmodule

// File: rtl/wpChainChecker.sv
module wpChainChecker #(
  parameter  int NCMP = 8,
  parameter  int DW   = 32,
  parameter  int CW   = 16,
  localparam int NWP  = NCMP + 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                dbgEnable,
  input logic                cpuInReset,
  input logic                singleStep,
  input logic [2:0]          accKind,
  input logic [2*NWP-1:0]    chainMode,
  input logic [NWP-1:0]      cntSel,
  input logic [NWP-1:0]      breakEn,
  input logic [1:0]          cntEnable,
  input logic                breakReq,
  input logic [NWP-1:0]      wpHit,
  input logic [CW-1:0]       cnt0,
  input logic [CW-1:0]       cnt1
);

  assert_inactive_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEnable || cpuInReset) |=> (wpHit == '0) && !breakReq && $stable(cnt0) && $stable(cnt1));

  assert_idle_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 3'd0) |=> (wpHit == '0) && !breakReq);

  assert_reserved_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    wpHit[0] |-> ($past(chainMode[1:0]) != 2'd3));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntEnable[0]) |-> (cnt0 == $past(cnt0) + CW'($countones(wpHit & ~$past(cntSel)))));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable[1] |=> $stable(cnt1));

  assert_break_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> ((|(wpHit & $past(breakEn))) || $past(singleStep && (accKind == 3'd1))));

endmodule

bind wpChainUnit wpChainChecker #(.NCMP(NCMP), .DW(DW), .CW(CW)) i_chk (.*);

// File: tb/test_wpChainUnit.sv
`timescale 1ns/1ps
module test_wpChainUnit;
  localparam int NCMP = 4;
  localparam int DW   = 8;
  localparam int CW   = 4;
  localparam int NWP  = NCMP + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgEnable = 1'b1, cpuInReset = 1'b0, singleStep = 1'b0;
  logic [2:0] accKind = '0;
  logic [DW-1:0] accValue = '0;
  logic [7:0] sCtrl [NCMP];
  logic [DW-1:0] sVal [NCMP];
  logic [NCMP*8-1:0] slotCtrl;
  logic [NCMP*DW-1:0] slotValue;
  logic [2*NWP-1:0] chainMode = '0;
  logic [NWP-1:0] cntSel = '0, breakEn = '0;
  logic [1:0] cntEnable = '0;
  logic [CW-1:0] cntMatch0 = '0, cntMatch1 = '0;
  logic breakReq;
  logic [NWP-1:0] wpHit;
  logic [CW-1:0] cnt0, cnt1;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int mCnt0 = 0, mCnt1 = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int s = 0; s < NCMP; s++) begin
      slotCtrl[s*8 +: 8]   = sCtrl[s];
      slotValue[s*DW +: DW] = sVal[s];
    end

  wpChainUnit #(.NCMP(NCMP), .DW(DW), .CW(CW)) i_wpChainUnit (.*);

  function automatic int toNum(logic [DW-1:0] v, bit sg);
    int r = int'(v);
    if (sg && v[DW-1]) r = r - (1 << DW);
    return r;
  endfunction

  // slot condition per R3 and R4
  function automatic bit slotCond(int s, logic [2:0] k, logic [DW-1:0] v);
    logic [7:0] c = sCtrl[s];
    bit kOk, cOk;
    int a, b;
    case (c[7:5])
      3'd1: kOk = (k == 1);
      3'd2: kOk = (k == 2);
      3'd3: kOk = (k == 3);
      3'd4: kOk = (k == 2) || (k == 3);
      3'd5: kOk = (k == 4);
      3'd6: kOk = (k == 5);
      3'd7: kOk = (k == 4) || (k == 5);
      default: kOk = 0;
    endcase
    a = toNum(v, c[4]);
    b = toNum(sVal[s], c[4]);
    case (c[3:1])
      3'd0: cOk = (v & sVal[s]) != 0;
      3'd1: cOk = a == b;
      3'd2: cOk = a != b;
      3'd3: cOk = a < b;
      3'd4: cOk = a <= b;
      3'd5: cOk = a > b;
      3'd6: cOk = a >= b;
      default: cOk = 0;
    endcase
    return c[0] && kOk && cOk;
  endfunction

  task automatic vec(input logic [2:0] k, input logic [DW-1:0] v, input string tag);
    bit act, ev, own, prev, res, brk;
    logic [NWP-1:0] eHit;
    int n0, n1;
    @(negedge clk);
    accKind = k;
    accValue = v;
    act = dbgEnable && !cpuInReset;
    ev  = act && (k >= 1 && k <= 5) && ((breakEn != 0) || (cntEnable != 0));
    eHit = '0;
    prev = 0;
    for (int i = 0; i < NWP; i++) begin
      if (i < NCMP)          own = slotCond(i, k, v);
      else if (i == NCMP)    own = (mCnt0 == int'(cntMatch0));
      else if (i == NCMP+1)  own = (mCnt1 == int'(cntMatch1));
      else                   own = 0;
      if (i == 0) prev = own;
      case (chainMode[2*i +: 2])
        2'd0: res = own;
        2'd1: res = own & prev;
        2'd2: res = own | prev;
        default: res = 0;
      endcase
      prev = res;
      eHit[i] = ev & res;
    end
    brk = (act && singleStep && k == 1) || ((eHit & breakEn) != 0);
    n0 = mCnt0; n1 = mCnt1;
    for (int i = 0; i < NWP; i++)
      if (eHit[i]) begin
        if (!cntSel[i] && cntEnable[0]) n0++;
        if (cntSel[i] && cntEnable[1]) n1++;
      end
    n0 = n0 % (1 << CW);
    n1 = n1 % (1 << CW);
    @(posedge clk);
    #1;
    vectors++;
    if (wpHit !== eHit || breakReq !== brk || int'(cnt0) != n0 || int'(cnt1) != n1) begin
      miscompares++;
      $display("FAIL %s: hit=%b brk=%b c0=%0d c1=%0d expected hit=%b brk=%b c0=%0d c1=%0d",
               tag, wpHit, breakReq, cnt0, cnt1, eHit, brk, n0, n1);
    end
    mCnt0 = n0;
    mCnt1 = n1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] refs [4] = '{8'h00, 8'h05, 8'h80, 8'hFF};
    logic [DW-1:0] vals [8] = '{8'h00, 8'h01, 8'h05, 8'h06, 8'h7F, 8'h80, 8'h81, 8'hFF};
    for (int s = 0; s < NCMP; s++) begin sCtrl[s] = '0; sVal[s] = '0; end
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    // R11: reset state
    if (wpHit !== '0 || breakReq !== 1'b0 || cnt0 !== '0 || cnt1 !== '0) begin
      miscompares++;
      $display("FAIL R11: hit=%b brk=%b c0=%0d c1=%0d expected all zero", wpHit, breakReq, cnt0, cnt1);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R3 / R4: exhaustive slot 0 sweep
    breakEn = 7'b0000001;
    for (int cd = 0; cd < 8; cd++)
      for (int sg = 0; sg < 2; sg++)
        for (int sl = 0; sl < 8; sl++)
          for (int r = 0; r < 4; r++) begin
            sCtrl[0] = {3'(sl), 1'(sg), 3'(cd), 1'b1};
            sVal[0] = refs[r];
            for (int k = 0; k < 6; k++)
              for (int x = 0; x < 8; x++)
                vec(3'(k), vals[x], "R3/R4 compare sweep");
          end
    // R3: present bit clear
    sCtrl[0] = {3'd1, 1'b0, 3'd1, 1'b0};
    sVal[0] = 8'h05;
    vec(3'd1, 8'h05, "R3 slot absent");

    // R5 / R6 / R7 / R8: every chain mode setting with counters running
    sCtrl[0] = {3'd1, 1'b0, 3'd1, 1'b1}; sVal[0] = 8'h10;
    sCtrl[1] = {3'd4, 1'b0, 3'd3, 1'b1}; sVal[1] = 8'h40;
    sCtrl[2] = {3'd5, 1'b0, 3'd0, 1'b1}; sVal[2] = 8'h0F;
    sCtrl[3] = {3'd7, 1'b1, 3'd6, 1'b1}; sVal[3] = 8'h00;
    breakEn = 7'b1010101;
    cntEnable = 2'b11;
    cntMatch0 = 4'd3;
    cntMatch1 = 4'd9;
    for (int m = 0; m < (1 << (2*NWP)); m++) begin
      chainMode = (2*NWP)'(m);
      cntSel = NWP'(m) ^ 7'h2A;
      vec(3'd1, 8'h10, "R5/R6/R7/R8 chain sweep");
      vec(3'd4, 8'h83, "R5/R6/R7/R8 chain sweep");
      if (m % 512 == 0) vec(3'd0, 8'h10, "R10 idle clears");
    end

    // R10: idle cycle after a hit
    chainMode = '0;
    vec(3'd1, 8'h10, "R10 hit cycle");
    vec(3'd0, 8'h10, "R10 idle clears");

    // R2: no enables -> no evaluation
    breakEn = '0; cntEnable = '0;
    vec(3'd1, 8'h10, "R2 no enables");
    // R9: single step overrides
    singleStep = 1'b1;
    vec(3'd1, 8'h33, "R9 step on fetch");
    vec(3'd2, 8'h33, "R9 no step on load");
    // R1: disabled and CPU reset
    breakEn = 7'h7F; cntEnable = 2'b11;
    dbgEnable = 1'b0;
    vec(3'd1, 8'h10, "R1 disabled");
    vec(3'd4, 8'h83, "R1 disabled");
    dbgEnable = 1'b1; cpuInReset = 1'b1;
    vec(3'd1, 8'h10, "R1 cpu reset");
    vec(3'd4, 8'h83, "R1 cpu reset");
    cpuInReset = 1'b0;
    vec(3'd1, 8'h10, "R9 step with watchpoints");
    singleStep = 1'b0;

    // R7: counter wrap with counter 1 disabled
    cntEnable = 2'b01; cntSel = '0;
    for (int w = 0; w < 20; w++) vec(3'd1, 8'h10, "R7 wrap");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule